// File: doc/BRIEF.md
# Extension Peripheral Routing Decoder

This block sits on the internal bus of a microcontroller and decides, for every access address, whether the access is served by one of five on-chip extension targets or is sent to the external memory interface. The five targets are an extension RAM, two CAN controller windows, a PWM window and a grouped I/O window that covers an extra port, a timer and an ADC input multiplexer. A small select register chooses which targets exist. A one-way global enable then activates the chosen set.

Software first writes the select register, then asserts the global enable. From then on the selection is frozen until reset. The decoder outputs are combinational from the address and the registered state. When a CAN controller is not claimed, its two port pins are released for general-purpose use, and the block flags this.

Top module: `periph_router`

## Requirements
- R1: After reset the select register holds 05h (CAN1 and extension RAM selected, the others not), the global enable is 0, and every access goes external.
- R2: A register write made while the global enable is 0 loads data bits 4..0 into the select bits: bit0 CAN1, bit1 CAN2, bit2 extension RAM, bit3 I/O group, bit4 PWM. The read port returns those five bits, and bits 15..5 read as zero.
- R3: Once the global enable is 1, register writes leave the select bits unchanged.
- R4: The global enable is set by a pulse on `glob_en_set` and stays 1 until reset.
- R5: The full 24-bit address is compared against these windows: RAM 008000h-00BFFFh, I/O group 00C000h-00C3FFh, PWM 00EC00h-00ECFFh, CAN2 00EE00h-00EEFFh, CAN1 00EF00h-00EFFFh.
- R6: A target's select output is 1 only when the address is in its window, the global enable is 1 and its select bit is 1.
- R7: An address outside 00EC00h-00EFFFh that no target claims sets `ext_access`.
- R8: An address in 00EC00h-00EFFFh goes external only when the CAN1, CAN2 and PWM select bits are all 0 or the global enable is 0. Otherwise no output is raised, even in an unclaimed part of that range.
- R9: `can1_pins_free` is 0 exactly when the global enable and select bit 0 are both 1. `can2_pins_free` is 0 exactly when the global enable and select bit 1 are both 1.
- R10: At most one target select is 1, and `ext_access` is never 1 together with a target select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the select register |
| cfg_wdata | input | 16 | Write data for the select register |
| cfg_rdata | output | 16 | Select register read value |
| glob_en_set | input | 1 | Sets the one-way global enable |
| glob_en | output | 1 | Current global enable state |
| addr | input | 24 | Access address |
| sel_ram | output | 1 | Extension RAM claims the access |
| sel_can1 | output | 1 | CAN1 window claims the access |
| sel_can2 | output | 1 | CAN2 window claims the access |
| sel_pwm | output | 1 | PWM window claims the access |
| sel_xio | output | 1 | I/O group window claims the access |
| ext_access | output | 1 | Access goes to external memory |
| can1_pins_free | output | 1 | CAN1 port pins available as general I/O |
| can2_pins_free | output | 1 | CAN2 port pins available as general I/O |

## Verification
A wrong select bit or a wrong enable state shows up at once on `cfg_rdata`, `glob_en` and the pin-release flags, in the cycle after the write or pulse that caused it. It also shows up in the same cycle as a misrouted address. Every one of the 32 select patterns is swept across the edges of every window, both before and after the global enable. This exposes a stuck bit, a misplaced boundary or a wrong shared-range rule in the first swept address that touches it. Writes attempted after the freeze are read back immediately, so a leak into the select bits cannot hide.

// File: rtl/periph_router_pkg.sv
package periph_router_pkg;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;
    localparam int NSEL   = 5;

    // select bit index per target (bit order is software visible)
    localparam int IDX_CAN1 = 0;
    localparam int IDX_CAN2 = 1;
    localparam int IDX_RAM  = 2;
    localparam int IDX_XIO  = 3;
    localparam int IDX_PWM  = 4;

    localparam logic [NSEL-1:0] RESET_SEL = 5'h05;

    localparam logic [ADDR_W-1:0] WIN_BASE [NSEL] =
        '{24'h00EF00, 24'h00EE00, 24'h008000, 24'h00C000, 24'h00EC00};
    localparam int WIN_LOG2 [NSEL] = '{8, 8, 14, 10, 8};

    // range shared by both CAN windows and the PWM window
    localparam logic [ADDR_W-1:0] SHARED_BASE = 24'h00EC00;
    localparam int                SHARED_LOG2 = 10;
    localparam logic [NSEL-1:0]   SHARED_MASK = 5'b10011;

    typedef struct packed {
        logic [NSEL-1:0] sel;
        logic            gen;
    } cfg_state_t;

endpackage

// File: rtl/periph_cfg_reg.sv
module periph_cfg_reg
    import periph_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [NSEL-1:0]   wsel,
    input  logic              gen_set,
    output logic [NSEL-1:0]   sel_q,
    output logic              gen_q
);

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && !st_q.gen) begin
            st_d.sel = wsel;
        end
        if (gen_set) begin
            st_d.gen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sel: RESET_SEL, gen: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q = st_q.sel;
    assign gen_q = st_q.gen;

    assert_gen_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q |=> gen_q);
    assert_sel_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gen_q |=> $stable(sel_q));
    assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !gen_q) |=> (sel_q == $past(wsel)));

endmodule

// File: rtl/periph_addr_decode.sv
module periph_addr_decode
    import periph_router_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [NSEL-1:0]   sel,
    input  logic              gen,
    output logic [NSEL-1:0]   claim,
    output logic              ext
);

    logic [NSEL-1:0] hit;
    logic            shared_hit;
    logic            shared_held;

    for (genvar gi = 0; gi < NSEL; gi++) begin : g_win
        localparam int SH = WIN_LOG2[gi];
        assign hit[gi]   = (addr >> SH) == (WIN_BASE[gi] >> SH);
        assign claim[gi] = hit[gi] && gen && sel[gi];
    end

    assign shared_hit  = (addr >> SHARED_LOG2) == (SHARED_BASE >> SHARED_LOG2);
    assign shared_held = shared_hit && gen && |(sel & SHARED_MASK);
    assign ext         = !(|claim) && !shared_held;

endmodule

// File: rtl/periph_router.sv
module periph_router
    import periph_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              glob_en_set,
    output logic              glob_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              sel_ram,
    output logic              sel_can1,
    output logic              sel_can2,
    output logic              sel_pwm,
    output logic              sel_xio,
    output logic              ext_access,
    output logic              can1_pins_free,
    output logic              can2_pins_free
);

    logic [NSEL-1:0] sel_q;
    logic            gen_q;
    logic [NSEL-1:0] claim;
    logic            unused_wdata_hi;

    assign unused_wdata_hi = ^cfg_wdata[DATA_W-1:NSEL];

    periph_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wsel    (cfg_wdata[NSEL-1:0]),
        .gen_set (glob_en_set),
        .sel_q   (sel_q),
        .gen_q   (gen_q)
    );

    periph_addr_decode u_dec (
        .addr  (addr),
        .sel   (sel_q),
        .gen   (gen_q),
        .claim (claim),
        .ext   (ext_access)
    );

    assign cfg_rdata      = {{(DATA_W-NSEL){1'b0}}, sel_q};
    assign glob_en        = gen_q;
    assign sel_can1       = claim[IDX_CAN1];
    assign sel_can2       = claim[IDX_CAN2];
    assign sel_ram        = claim[IDX_RAM];
    assign sel_xio        = claim[IDX_XIO];
    assign sel_pwm        = claim[IDX_PWM];
    assign can1_pins_free = !(gen_q && sel_q[IDX_CAN1]);
    assign can2_pins_free = !(gen_q && sel_q[IDX_CAN2]);

    assert_onehot_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ram, sel_can1, sel_can2, sel_pwm, sel_xio}));
    assert_ext_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_access |-> ({sel_ram, sel_can1, sel_can2, sel_pwm, sel_xio} == 5'b0));
    assert_off_external_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> (ext_access && can1_pins_free && can2_pins_free));
    assert_can_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_can1 |-> !can1_pins_free);
    assert_readback_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[DATA_W-1:NSEL] == '0);

endmodule

// File: tb/sim_periph_router.sv
module sim_periph_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        glob_en_set = 1'b0;
    logic        glob_en;
    logic [23:0] addr = '0;
    logic        sel_ram, sel_can1, sel_can2, sel_pwm, sel_xio;
    logic        ext_access, can1_pins_free, can2_pins_free;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    periph_router u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .glob_en_set(glob_en_set), .glob_en(glob_en),
        .addr(addr), .sel_ram(sel_ram), .sel_can1(sel_can1), .sel_can2(sel_can2),
        .sel_pwm(sel_pwm), .sel_xio(sel_xio), .ext_access(ext_access),
        .can1_pins_free(can1_pins_free), .can2_pins_free(can2_pins_free)
    );

    logic [23:0] alist [20] = '{24'h007FFF, 24'h008000, 24'h00BFFF, 24'h00C000,
        24'h00C3FF, 24'h00C400, 24'h00EBFF, 24'h00EC00, 24'h00ECFF, 24'h00ED00,
        24'h00EDFF, 24'h00EE00, 24'h00EEFF, 24'h00EF00, 24'h00EFFF, 24'h00F000,
        24'h018000, 24'h01EF00, 24'h000000, 24'hFFFFFF};

    function automatic bit inr(logic [23:0] a, logic [23:0] lo, logic [23:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    // {ram, can1, can2, pwm, xio, ext, pins1, pins2}
    function automatic logic [7:0] model(logic [4:0] s, bit g, logic [23:0] a);
        bit r, c1, c2, p, x, sh, e;
        r  = g && s[2] && inr(a, 24'h008000, 24'h00BFFF);
        x  = g && s[3] && inr(a, 24'h00C000, 24'h00C3FF);
        p  = g && s[4] && inr(a, 24'h00EC00, 24'h00ECFF);
        c2 = g && s[1] && inr(a, 24'h00EE00, 24'h00EEFF);
        c1 = g && s[0] && inr(a, 24'h00EF00, 24'h00EFFF);
        sh = g && (s[0] || s[1] || s[4]) && inr(a, 24'h00EC00, 24'h00EFFF);
        e  = !(r || x || p || c1 || c2) && !sh;
        return {r, c1, c2, p, x, e, !(g && s[0]), !(g && s[1])};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sweep(logic [4:0] s, bit g, string req);
        for (int i = 0; i < 20; i++) begin
            addr = alist[i];
            #1;
            check(req, {24'h0, sel_ram, sel_can1, sel_can2, sel_pwm, sel_xio,
                        ext_access, can1_pins_free, can2_pins_free},
                  {24'h0, model(s, g, alist[i])});
        end
    endtask

    initial begin
        @(negedge clk);
        tick();
        // R1: reset state
        check("R1 rdata", {16'h0, cfg_rdata}, 32'h5);
        check("R1 glob_en", {31'h0, glob_en}, 32'h0);
        sweep(5'h05, 1'b0, "R1 reset routing");
        rst_n = 1'b1;
        tick();
        for (int c = 0; c < 32; c++) begin
            rst_n = 1'b0;
            tick();
            rst_n = 1'b1;
            cfg_we = 1'b1;
            cfg_wdata = 16'hA5A0 | 16'(c);
            tick();
            cfg_we = 1'b0;
            check("R2 readback", {16'h0, cfg_rdata}, 32'(c));
            sweep(5'(c), 1'b0, "R6/R9 before enable");
            glob_en_set = 1'b1;
            tick();
            glob_en_set = 1'b0;
            tick();
            tick();
            check("R4 enable sticky", {31'h0, glob_en}, 32'h1);
            cfg_we = 1'b1;
            cfg_wdata = ~(16'h0 | 16'(c));
            tick();
            cfg_we = 1'b0;
            check("R3 frozen", {16'h0, cfg_rdata}, 32'(c));
            sweep(5'(c), 1'b1, "R5/R6/R7/R8/R9/R10 enabled");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule